// File: doc/BRIEF.md
# Standby Wake-Up and Clock-Settling Controller

This block sequences a small microcontroller into and out of a clock-stopped software standby state. While the core runs, a sleep request takes the block into standby, provided standby is selected and no watchdog or bus-release setting forbids it. Entering standby stops both the oscillator and the chip clock.

Four things can end standby. An NMI, or an enabled and unmasked IRQ line, turns the oscillator back on. The block then counts a settling interval before it gives the clock back to the chip and pulses an interrupt-entry strobe. The length of that interval is programmed by a settle-select code and a clock-divider code. The reset pin restores the clock at once and skips the count. Releasing the reset pin pulses a reset-entry strobe. A low hardware-standby pin wins over everything and shuts the clock and oscillator down from any state. When that pin is released the block goes into a reset-held condition.

Top module: `stby_wake_ctrl`

## Requirements
- R1: In RUN, a `sleep_req` that is sampled with `stby_sel`=1 and entry permitted gives `osc_en`=0 and `clk_en`=0 from the next cycle on.
- R2: Entry is refused, so that `clk_en` stays 1, when `stby_sel`=0, or when `wdog_run`=1 and `wdog_mode`=1 together, or when `busrel_en`=1. `wdog_run`=1 with `wdog_mode`=0 does not block entry.
- R3: In standby, `nmi`=1 raises `osc_en` on the next cycle while `clk_en` stays 0. This holds regardless of `irq_en` and `irq_mask`.
- R4: Line n of `irq` wakes the block only when `irq_en[n]`=1 and `irq_mask`=0. Any other IRQ activity leaves `osc_en`=0.
- R5: After an interrupt wake, `osc_en`=1 with `clk_en`=0 lasts exactly 2^(BASE_EXP + min(`settle_sel`,5) + `clk_div`) cycles. Codes 6 and 7 of `settle_sel` behave like code 5.
- R6: `wake_irq` is a one-cycle pulse on the first cycle that `clk_en` is 1 after settling.
- R7: A low `pin_reset_n` in standby or during settling gives `osc_en`=1 and `clk_en`=1 on the next cycle. It aborts any count, so no `wake_irq` follows.
- R8: When `pin_reset_n` returns high in the reset-held condition, `wake_rst` pulses for exactly one cycle and the block resumes RUN.
- R9: A low `pin_hwstby_n` gives `osc_en`=0 and `clk_en`=0 on the next cycle from any state, and holds that until the pin is high. After that the block is reset-held, with `osc_en`=1, `clk_en`=1 and no strobe, until `pin_reset_n` is high.
- R10: After `rst_n` the block is in RUN with `osc_en`=1, `clk_en`=1 and both strobes 0.
- R11: `clk_en` is never 1 while `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| stby_sel | input | 1 | Selects software standby on a sleep request |
| sleep_req | input | 1 | Sleep request from the core |
| wdog_run | input | 1 | Watchdog counter running |
| wdog_mode | input | 1 | Timer is in watchdog (not interval) mode |
| busrel_en | input | 1 | Bus release is permitted |
| settle_sel | input | 3 | Settling-time select code |
| clk_div | input | 2 | Clock-divider code, lengthens the settling time |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | N_IRQ | External interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| irq_mask | input | 1 | CPU-level interrupt mask |
| pin_reset_n | input | 1 | Reset pin, active low |
| pin_hwstby_n | input | 1 | Hardware-standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Chip clock enable |
| wake_irq | output | 1 | Interrupt-entry strobe |
| wake_rst | output | 1 | Reset-entry strobe |

## Verification
The bench builds the block with BASE_EXP=2 and N_IRQ=3. That makes the longest settling interval 1024 cycles, so the bench can time every one of the 32 select and divider pairs exactly, including the two reserved codes. Three IRQ lines make the whole enable and mask space small enough to cover both with random patterns and with line-by-line directed cases. The short intervals also let the bench confirm that a reset mid-count suppresses the interrupt strobe for longer than the full count would have taken.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    PS_RUN     = 3'd0,
    PS_SWSTBY  = 3'd1,
    PS_SETTLE  = 3'd2,
    PS_HWSTBY  = 3'd3,
    PS_RSTHOLD = 3'd4
  } pstate_t;

  localparam int SEL_W      = 3;
  localparam int DIV_W      = 2;
  localparam int SEL_TOP    = 5;                 // highest non-reserved select code
  localparam int DIV_TOP    = (1 << DIV_W) - 1;
endpackage

// File: rtl/stby_gate.sv
module stby_gate #(
  parameter int N_IRQ = 3
) (
  input  logic             stby_sel,
  input  logic             wdog_run,
  input  logic             wdog_mode,
  input  logic             busrel_en,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_mask,
  output logic             entry_ok,
  output logic             wake
);
  logic [N_IRQ-1:0] line_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_hit[i] = irq[i] & irq_en[i];
  end

  assign entry_ok = stby_sel & ~(wdog_run & wdog_mode) & ~busrel_en;
  assign wake     = nmi | ((|line_hit) & ~irq_mask);
endmodule

// File: rtl/settle_timer.sv
module settle_timer
  import stby_pkg::*;
#(
  parameter int BASE_EXP = 13,
  localparam int CNT_W   = BASE_EXP + SEL_TOP + DIV_TOP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             done
);
  logic [SEL_W-1:0] sel_c;
  logic [7:0]       exp_w;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    sel_c    = (int'(sel) > SEL_TOP) ? SEL_W'(SEL_TOP) : sel;
    exp_w    = 8'(BASE_EXP) + 8'(sel_c) + 8'(div);
    load_val = (CNT_W'(1) << exp_w) - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);

  // R5: a fresh load with a nonzero exponent never reports done at once
  a_r5_load_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    load && (exp_w != 8'd0) |=> !done);
  // R5: while running the count only moves downward by one
  a_r5_steady_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && !done |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic entry_ok,
  input  logic wake,
  input  logic pin_reset_n,
  input  logic pin_hwstby_n,
  input  logic tmr_done,
  output logic tmr_load,
  output logic tmr_run,
  output logic osc_en,
  output logic clk_en,
  output logic wake_irq,
  output logic wake_rst
);
  pstate_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (!pin_hwstby_n) begin
      st_nx = PS_HWSTBY;
    end else begin
      case (st)
        PS_RUN: begin
          if (!pin_reset_n)                st_nx = PS_RSTHOLD;
          else if (sleep_req && entry_ok)  st_nx = PS_SWSTBY;
        end
        PS_SWSTBY: begin
          if (!pin_reset_n)  st_nx = PS_RSTHOLD;
          else if (wake)     st_nx = PS_SETTLE;
        end
        PS_SETTLE: begin
          if (!pin_reset_n)  st_nx = PS_RSTHOLD;
          else if (tmr_done) st_nx = PS_RUN;
        end
        PS_HWSTBY:  st_nx = PS_RSTHOLD;
        PS_RSTHOLD: if (pin_reset_n) st_nx = PS_RUN;
        default:    st_nx = PS_RSTHOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_RUN;
      wake_irq <= 1'b0;
      wake_rst <= 1'b0;
    end else begin
      st       <= st_nx;
      wake_irq <= (st == PS_SETTLE)  && (st_nx == PS_RUN);
      wake_rst <= (st == PS_RSTHOLD) && (st_nx == PS_RUN);
    end
  end

  assign tmr_load = (st == PS_SWSTBY) && (st_nx == PS_SETTLE);
  assign tmr_run  = (st == PS_SETTLE);
  assign osc_en   = (st == PS_RUN) || (st == PS_SETTLE) || (st == PS_RSTHOLD);
  assign clk_en   = (st == PS_RUN) || (st == PS_RSTHOLD);

  a_r11_clk_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> osc_en);
  a_r9_hw_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_hwstby_n |=> !osc_en && !clk_en);
  a_r7_reset_restores: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hwstby_n && !pin_reset_n |=> osc_en && clk_en);
  a_r6_irq_on_clock_return: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> clk_en && !$past(clk_en));
  a_r8_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> !wake_rst);
  a_r4_quiet_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_SWSTBY) && !wake && pin_reset_n && pin_hwstby_n |=> !osc_en);
  a_r2_refused_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_RUN) && !entry_ok && pin_reset_n && pin_hwstby_n |=> clk_en);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int BASE_EXP = 13,
  parameter int N_IRQ    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_sel,
  input  logic             sleep_req,
  input  logic             wdog_run,
  input  logic             wdog_mode,
  input  logic             busrel_en,
  input  logic [2:0]       settle_sel,
  input  logic [1:0]       clk_div,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_mask,
  input  logic             pin_reset_n,
  input  logic             pin_hwstby_n,
  output logic             osc_en,
  output logic             clk_en,
  output logic             wake_irq,
  output logic             wake_rst
);
  logic entry_ok, wake, tmr_load, tmr_run, tmr_done;

  stby_gate #(.N_IRQ(N_IRQ)) u_gate (
    .stby_sel (stby_sel),
    .wdog_run (wdog_run),
    .wdog_mode(wdog_mode),
    .busrel_en(busrel_en),
    .nmi      (nmi),
    .irq      (irq),
    .irq_en   (irq_en),
    .irq_mask (irq_mask),
    .entry_ok (entry_ok),
    .wake     (wake)
  );

  settle_timer #(.BASE_EXP(BASE_EXP)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .run  (tmr_run),
    .sel  (settle_sel),
    .div  (clk_div),
    .done (tmr_done)
  );

  stby_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .entry_ok    (entry_ok),
    .wake        (wake),
    .pin_reset_n (pin_reset_n),
    .pin_hwstby_n(pin_hwstby_n),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_run     (tmr_run),
    .osc_en      (osc_en),
    .clk_en      (clk_en),
    .wake_irq    (wake_irq),
    .wake_rst    (wake_rst)
  );
endmodule

// File: tb/sim_stby_wake_ctrl.sv
module sim_stby_wake_ctrl;
  localparam int PERIOD = 10;
  localparam int BE     = 2;
  localparam int NI     = 3;

  logic clk = 1'b0;
  logic rst_n, stby_sel, sleep_req, wdog_run, wdog_mode, busrel_en;
  logic [2:0] settle_sel;
  logic [1:0] clk_div;
  logic nmi, irq_mask, pin_reset_n, pin_hwstby_n;
  logic [NI-1:0] irq, irq_en;
  logic osc_en, clk_en, wake_irq, wake_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  stby_wake_ctrl #(.BASE_EXP(BE), .N_IRQ(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_sel(stby_sel), .sleep_req(sleep_req),
    .wdog_run(wdog_run), .wdog_mode(wdog_mode), .busrel_en(busrel_en),
    .settle_sel(settle_sel), .clk_div(clk_div), .nmi(nmi), .irq(irq),
    .irq_en(irq_en), .irq_mask(irq_mask), .pin_reset_n(pin_reset_n),
    .pin_hwstby_n(pin_hwstby_n), .osc_en(osc_en), .clk_en(clk_en),
    .wake_irq(wake_irq), .wake_rst(wake_rst));

  function automatic int settle_len(int sel, int dv);
    int s = (sel > 5) ? 5 : sel;
    return 1 << (BE + s + dv);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic go_stby();
    stby_sel = 1'b1; sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
    chk(!osc_en && !clk_en, "R1 standby entry", {osc_en, clk_en}, 0);
  endtask

  task automatic via_reset(string tag);
    pin_reset_n = 1'b0;
    step(1);
    chk(osc_en && clk_en, {"R7 reset restores clock ", tag}, {osc_en, clk_en}, 3);
    pin_reset_n = 1'b1;
    step(1);
    chk(wake_rst && clk_en, {"R8 reset strobe ", tag}, wake_rst, 1);
    step(1);
    chk(!wake_rst, {"R8 reset strobe single ", tag}, wake_rst, 0);
  endtask

  task automatic settle_and_check(int sel, int dv, string tag);
    int cnt = 0;
    while (osc_en && !clk_en && cnt < 5000) begin
      cnt++;
      step(1);
    end
    chk(cnt == settle_len(sel, dv), {"R5 settle length ", tag}, cnt, settle_len(sel, dv));
    chk(wake_irq && clk_en, {"R6 irq strobe ", tag}, wake_irq, 1);
    step(1);
    chk(!wake_irq, {"R6 irq strobe single ", tag}, wake_irq, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; stby_sel = 1'b0; sleep_req = 1'b0; wdog_run = 1'b0;
    wdog_mode = 1'b0; busrel_en = 1'b0; settle_sel = 3'd0; clk_div = 2'd0;
    nmi = 1'b0; irq = '0; irq_en = '0; irq_mask = 1'b0;
    pin_reset_n = 1'b1; pin_hwstby_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(osc_en && clk_en && !wake_irq && !wake_rst, "R10 reset state",
        {osc_en, clk_en, wake_irq, wake_rst}, 4'b1100);

    // R2: refused entries
    stby_sel = 1'b0; sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    chk(clk_en, "R2 refused, select off", clk_en, 1);
    stby_sel = 1'b1; wdog_run = 1'b1; wdog_mode = 1'b1;
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    chk(clk_en, "R2 refused, watchdog", clk_en, 1);
    wdog_mode = 1'b0; busrel_en = 1'b1;
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    chk(clk_en, "R2 refused, bus release", clk_en, 1);
    busrel_en = 1'b0;
    go_stby();   // R2: watchdog running in interval mode allows entry
    wdog_run = 1'b0;
    step(4);
    chk(!osc_en, "R1 standby holds", osc_en, 0);
    via_reset("from standby");

    // R3/R5/R6: every select and divider pair, woken by NMI with IRQs masked
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 4; d++) begin
        go_stby();
        settle_sel = 3'(s); clk_div = 2'(d);
        irq_mask = 1'b1; irq_en = '0;
        nmi = 1'b1; step(1); nmi = 1'b0;
        chk(osc_en && !clk_en, "R3 nmi starts oscillator", {osc_en, clk_en}, 2);
        settle_and_check(s, d, "sweep");
      end
    end
    irq_mask = 1'b0;

    // R4: each line alone, enabled and unmasked, wakes
    for (int i = 0; i < NI; i++) begin
      go_stby();
      settle_sel = 3'd0; clk_div = 2'd0;
      irq = NI'(1 << i); irq_en = NI'(1 << i);
      step(1); irq = '0;
      chk(osc_en, "R4 enabled line wakes", osc_en, 1);
      settle_and_check(0, 0, "line");
    end

    // R4: random line / enable / mask patterns
    for (int k = 0; k < 60; k++) begin
      bit expw;
      go_stby();
      settle_sel = 3'($urandom_range(0, 7)); clk_div = 2'($urandom_range(0, 3));
      irq = NI'($urandom); irq_en = NI'($urandom); irq_mask = 1'($urandom);
      expw = (|(irq & irq_en)) && !irq_mask;
      step(1);
      irq = '0;
      chk(osc_en == expw, "R4 qualified wake", osc_en, expw);
      if (expw) settle_and_check(int'(settle_sel), int'(clk_div), "random");
      else      via_reset("after ignored irq");
    end
    irq_mask = 1'b0; irq_en = '0;

    // R7: reset aborts a long settling count
    begin
      bit seen = 1'b0;
      go_stby();
      settle_sel = 3'd7; clk_div = 2'd3;
      nmi = 1'b1; step(1); nmi = 1'b0;
      step(10);
      chk(osc_en && !clk_en, "R7 still settling", {osc_en, clk_en}, 2);
      pin_reset_n = 1'b0; step(1);
      chk(clk_en && !wake_irq, "R7 reset mid-settle", {clk_en, wake_irq}, 2);
      pin_reset_n = 1'b1; step(1);
      chk(wake_rst, "R8 strobe after abort", wake_rst, 1);
      for (int c = 0; c < 1100; c++) begin
        if (wake_irq) seen = 1'b1;
        step(1);
      end
      chk(!seen, "R7 no late irq strobe", seen, 0);
    end

    // R9: hardware standby from RUN, held through reset and NMI
    pin_hwstby_n = 1'b0; step(1);
    chk(!osc_en && !clk_en, "R9 hw standby from run", {osc_en, clk_en}, 0);
    nmi = 1'b1; pin_reset_n = 1'b0; step(5); nmi = 1'b0;
    chk(!osc_en && !clk_en, "R9 hw standby holds", {osc_en, clk_en}, 0);
    pin_hwstby_n = 1'b1; step(1);
    chk(osc_en && clk_en && !wake_rst, "R9 reset-held after hw exit",
        {osc_en, clk_en, wake_rst}, 6);
    step(3);
    chk(!wake_rst, "R9 held while reset low", wake_rst, 0);
    pin_reset_n = 1'b1; step(1);
    chk(wake_rst, "R8 strobe after hw standby", wake_rst, 1);
    step(1);

    // R9: hardware standby interrupts a settling count
    go_stby();
    settle_sel = 3'd5; nmi = 1'b1; step(1); nmi = 1'b0;
    step(3);
    pin_hwstby_n = 1'b0; step(1);
    chk(!osc_en && !clk_en, "R9 hw standby from settle", {osc_en, clk_en}, 0);
    pin_hwstby_n = 1'b1; step(1);
    chk(clk_en && osc_en, "R11 clock with oscillator", {osc_en, clk_en}, 3);
    step(1);
    chk(wake_rst && !wake_irq, "R8 strobe, no irq strobe", {wake_rst, wake_irq}, 2);

    step(2);
    summary();
  end
endmodule